// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block runs one external memory access at a time on behalf of a processor core. When the core raises a request, the block takes a snapshot of the direction, address, space select, write data and programmed wait count. It then steps through four bus phases, T0 to T3, one clock per phase. Along the way it drives active-low bus-strobe, read-strobe and write-strobe pins, plus an enable for the outgoing half of a 16-bit data bus. At the end it returns read data together with a one-clock completion pulse.

The access can be stretched by wait states. Each wait repeats phase T2 with every strobe held. The number of waits is the larger of two counts. The first is the programmed count taken at acceptance. The second is the count that an active-low acknowledge input demands. Acknowledge is sampled at every phase edge of an access and is ignored outside one.

Strobe pins carry an output enable. That enable is low during reset and whenever the bus is not granted to this block.

Top module: `mbus_seq`

## Requirements
- R1: While reset is asserted, `ctl_oe`, `dbus_oe` and `core_done` are low and `mem_bs_n`, `mem_rd_n` and `mem_wr_n` are high.
- R2: `mem_bs_n` is low during exactly the first two phases of an access (T0 and T1) and high at all other times.
- R3: In a write, `mem_wr_n` is low from T1 through the last T2 period and `mem_rd_n` stays high. `dbus_oe` is high from the first T2 period through T3, with `dbus_out` equal to the write data taken at acceptance.
- R4: In a read, `mem_rd_n` is low from T1 through the last T2 period and `dbus_oe` stays low. `core_rdata` takes the `dbus_in` value present at the clock edge that ends the last T2 period. `core_done` is high for the single T3 clock, and the clock after T3 is idle.
- R5: An access occupies 4 + N clocks, where N = max(W, K). W is `wait_prog` taken at acceptance, and K is the count demanded by acknowledge as defined in R7.
- R6: If `mem_ack_n` is low at the acceptance edge and W is 0, the access has no wait states, even when acknowledge is high at every later edge.
- R7: Number the clock edges of an access from 0 at the acceptance edge, and let F be the first edge at which `mem_ack_n` is sampled low. Then K = max(0, F - 2). A low sample is retained for the rest of the access even if acknowledge returns high.
- R8: `mem_ack_n` has no effect while no access is in progress. Toggling it while idle leaves every output unchanged and does not shorten the next access.
- R9: While either `mem_rd_n` or `mem_wr_n` is low, `mem_addr` and `mem_space` equal the values taken at acceptance. Later changes on the core inputs do not affect them.
- R10: While `bus_grant` is low, `ctl_oe` and `dbus_oe` are low and no request is accepted.
- R11: A request raised while an access is in progress is ignored. A new request is accepted only from the idle state after `core_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus phase per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_grant | input | 1 | High while this block owns the external bus |
| core_req | input | 1 | Access request, sampled while idle |
| core_wr | input | 1 | 1 = write, 0 = read |
| core_space | input | 1 | Program/data space select for the access |
| core_addr | input | 16 | Access address |
| core_wdata | input | 16 | Write data |
| wait_prog | input | 4 | Programmed wait-state count |
| core_rdata | output | 16 | Read data captured at the end of the last T2 |
| core_done | output | 1 | One-clock completion pulse in T3 |
| mem_addr | output | 16 | External address |
| mem_space | output | 1 | External space select |
| mem_bs_n | output | 1 | Active-low bus strobe |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_wr_n | output | 1 | Active-low write strobe |
| ctl_oe | output | 1 | Output enable for the three strobe pins |
| mem_ack_n | input | 1 | Active-low transfer acknowledge |
| dbus_in | input | 16 | Data bus, incoming half |
| dbus_out | output | 16 | Data bus, outgoing half |
| dbus_oe | output | 1 | Output enable for dbus_out |

## Verification
The hardest situation to reach is an access whose length depends on exactly which edge first saw acknowledge low. The acknowledge count and the programmed count must be made to compete in both directions. A short acknowledge pulse must arrive before T2, and then acknowledge must return high during T2. The bench drives `mem_ack_n` edge by edge, indexed from the acceptance edge. It uses both a held-low mode and a single-edge pulse mode, and pairs each with programmed counts below, equal to and above the acknowledge count. It predicts N from the formula in R5 and R7. It also presents read data only at the edge that should capture it.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T0   = 3'd1,
    PH_T1   = 3'd2,
    PH_T2   = 3'd3,
    PH_T3   = 3'd4
  } phase_e;

  typedef struct packed {
    logic bs_n;
    logic rd_n;
    logic wr_n;
    logic drive;
    logic done;
  } pins_t;

  // The last T2 period may end once the programmed waits are used up
  // and a low acknowledge has been seen in this access.
  function automatic logic t2_may_end(input int unsigned waits_done,
                                      input int unsigned waits_prog,
                                      input logic        ack_held);
    return ack_held && (waits_done >= waits_prog);
  endfunction

  // Phases in which acknowledge samples are collected.
  function automatic logic ack_window(input phase_e ph);
    return (ph == PH_T0) || (ph == PH_T1) || (ph == PH_T2);
  endfunction

  // Pin levels for a phase and direction (before output enables).
  function automatic pins_t phase_pins(input phase_e ph, input logic is_wr);
    pins_t p;
    p = '{bs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, drive: 1'b0, done: 1'b0};
    case (ph)
      PH_T0: p.bs_n = 1'b0;
      PH_T1: begin
        p.bs_n = 1'b0;
        p.rd_n = is_wr;
        p.wr_n = ~is_wr;
      end
      PH_T2: begin
        p.rd_n  = is_wr;
        p.wr_n  = ~is_wr;
        p.drive = is_wr;
      end
      PH_T3: begin
        p.drive = is_wr;
        p.done  = 1'b1;
      end
      default: ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/mbus_phase_fsm.sv
module mbus_phase_fsm
  import mbus_pkg::*;
#(
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_ok,
  input  logic          ack_held,
  input  logic [WW-1:0] wprog_snap,
  output phase_e        phase,
  output logic          ev_start,
  output logic          ev_t2_exit,
  output logic [WW-1:0] wcnt
);
  localparam logic [WW-1:0] WMAX = {WW{1'b1}};

  phase_e phase_nx;

  assign ev_start   = (phase == PH_IDLE) && start_ok;
  assign ev_t2_exit = (phase == PH_T2) &&
                      t2_may_end(32'(wcnt), 32'(wprog_snap), ack_held);

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_IDLE: if (start_ok) phase_nx = PH_T0;
      PH_T0:   phase_nx = PH_T1;
      PH_T1:   phase_nx = PH_T2;
      PH_T2:   if (ev_t2_exit) phase_nx = PH_T3;
      PH_T3:   phase_nx = PH_IDLE;
      default: phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nx;
  end

  // Wait counter: counts completed T2 repeats, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= '0;
    end else if (ev_start) begin
      wcnt <= '0;
    end else if ((phase == PH_T2) && !ev_t2_exit && (wcnt != WMAX)) begin
      wcnt <= wcnt + WW'(1);
    end
  end
endmodule

// File: rtl/mbus_ack_track.sv
module mbus_ack_track
  import mbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e phase,
  input  logic   ev_start,
  input  logic   ack_n,
  output logic   ack_held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_held <= 1'b0;
    end else if (ev_start) begin
      ack_held <= ~ack_n;
    end else if (ack_window(phase)) begin
      ack_held <= ack_held | ~ack_n;
    end else begin
      ack_held <= 1'b0;
    end
  end
endmodule

// File: rtl/mbus_xfer_regs.sv
module mbus_xfer_regs #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_start,
  input  logic          ev_t2_exit,
  input  logic          in_wr,
  input  logic          in_space,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_wdata,
  input  logic [WW-1:0] in_wprog,
  input  logic [DW-1:0] bus_rdata,
  output logic          is_wr,
  output logic          space_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [WW-1:0] wprog_q,
  output logic [DW-1:0] rdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_wr   <= 1'b0;
      space_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      wprog_q <= '0;
    end else if (ev_start) begin
      is_wr   <= in_wr;
      space_q <= in_space;
      addr_q  <= in_addr;
      wdata_q <= in_wdata;
      wprog_q <= in_wprog;
    end
  end

  // Read data is latched on the edge that releases the read strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    rdata_q <= '0;
    else if (ev_t2_exit && !is_wr) rdata_q <= bus_rdata;
  end
endmodule

// File: rtl/mbus_strobe_dec.sv
module mbus_strobe_dec
  import mbus_pkg::*;
(
  input  phase_e phase,
  input  logic   is_wr,
  input  logic   pin_en,
  output logic   bs_n,
  output logic   rd_n,
  output logic   wr_n,
  output logic   drive,
  output logic   done
);
  pins_t pv;

  always_comb begin
    pv    = phase_pins(phase, is_wr);
    bs_n  = pv.bs_n;
    rd_n  = pv.rd_n;
    wr_n  = pv.wr_n;
    drive = pv.drive & pin_en;
    done  = pv.done;
  end
endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_grant,
  input  logic          core_req,
  input  logic          core_wr,
  input  logic          core_space,
  input  logic [AW-1:0] core_addr,
  input  logic [DW-1:0] core_wdata,
  input  logic [WW-1:0] wait_prog,
  output logic [DW-1:0] core_rdata,
  output logic          core_done,
  output logic [AW-1:0] mem_addr,
  output logic          mem_space,
  output logic          mem_bs_n,
  output logic          mem_rd_n,
  output logic          mem_wr_n,
  output logic          ctl_oe,
  input  logic          mem_ack_n,
  input  logic [DW-1:0] dbus_in,
  output logic [DW-1:0] dbus_out,
  output logic          dbus_oe
);
  // Named internal events, visible to the bound checker.
  phase_e        phase;
  logic          ev_start;
  logic          ev_t2_exit;
  logic          ack_held;
  logic [WW-1:0] wcnt;
  logic [WW-1:0] wprog_snap;
  logic          is_wr;
  logic          start_ok;

  assign ctl_oe   = rst_n & bus_grant;
  assign start_ok = core_req & bus_grant;

  mbus_phase_fsm #(.WW(WW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_ok   (start_ok),
    .ack_held   (ack_held),
    .wprog_snap (wprog_snap),
    .phase      (phase),
    .ev_start   (ev_start),
    .ev_t2_exit (ev_t2_exit),
    .wcnt       (wcnt)
  );

  mbus_ack_track u_ack (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .ev_start (ev_start),
    .ack_n    (mem_ack_n),
    .ack_held (ack_held)
  );

  mbus_xfer_regs #(.AW(AW), .DW(DW), .WW(WW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_start   (ev_start),
    .ev_t2_exit (ev_t2_exit),
    .in_wr      (core_wr),
    .in_space   (core_space),
    .in_addr    (core_addr),
    .in_wdata   (core_wdata),
    .in_wprog   (wait_prog),
    .bus_rdata  (dbus_in),
    .is_wr      (is_wr),
    .space_q    (mem_space),
    .addr_q     (mem_addr),
    .wdata_q    (dbus_out),
    .wprog_q    (wprog_snap),
    .rdata_q    (core_rdata)
  );

  mbus_strobe_dec u_dec (
    .phase  (phase),
    .is_wr  (is_wr),
    .pin_en (ctl_oe),
    .bs_n   (mem_bs_n),
    .rd_n   (mem_rd_n),
    .wr_n   (mem_wr_n),
    .drive  (dbus_oe),
    .done   (core_done)
  );
endmodule

// File: rtl/mbus_seq_chk.sv
module mbus_seq_chk
  import mbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int WW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_grant,
  input logic          ctl_oe,
  input logic          mem_bs_n,
  input logic          mem_rd_n,
  input logic          mem_wr_n,
  input logic          dbus_oe,
  input logic          core_done,
  input logic [AW-1:0] mem_addr,
  input logic          mem_space,
  input phase_e        phase,
  input logic          ev_start,
  input logic          ev_t2_exit,
  input logic          ack_held,
  input logic [WW-1:0] wprog_snap
);
  localparam int CW = WW + 1;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] t2_seen;
  logic          stb_low;

  assign stb_low = !mem_rd_n || !mem_wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     t2_seen <= '0;
    else if (ev_start)                              t2_seen <= '0;
    else if ((phase == PH_T2) && (t2_seen != CMAX)) t2_seen <= t2_seen + CW'(1);
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!ctl_oe && !dbus_oe && !core_done && mem_bs_n && mem_rd_n && mem_wr_n));

  p_bs_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !mem_bs_n);

  p_bs_two_phases_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_bs_n && $past(!mem_bs_n)) |=> mem_bs_n);

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rd_n && !mem_wr_n));

  p_no_drive_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dbus_oe |-> mem_rd_n);

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |=> !core_done);

  p_wait_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_t2_exit |-> (t2_seen >= {1'b0, wprog_snap}));

  p_idle_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !ack_held);

  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stb_low |=> (!stb_low || ($stable(mem_addr) && $stable(mem_space))));

  p_no_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_grant |-> (!ctl_oe && !dbus_oe && !ev_start));

  p_one_at_time_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |-> !ev_start);
endmodule

bind mbus_seq mbus_seq_chk #(.AW(AW), .WW(WW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_grant  (bus_grant),
  .ctl_oe     (ctl_oe),
  .mem_bs_n   (mem_bs_n),
  .mem_rd_n   (mem_rd_n),
  .mem_wr_n   (mem_wr_n),
  .dbus_oe    (dbus_oe),
  .core_done  (core_done),
  .mem_addr   (mem_addr),
  .mem_space  (mem_space),
  .phase      (phase),
  .ev_start   (ev_start),
  .ev_t2_exit (ev_t2_exit),
  .ack_held   (ack_held),
  .wprog_snap (wprog_snap)
);

// File: tb/sim_mbus_seq.sv
`timescale 1ns/1ps
module sim_mbus_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_grant = 1'b1;
  logic        core_req = 1'b0;
  logic        core_wr = 1'b0;
  logic        core_space = 1'b0;
  logic [15:0] core_addr = '0;
  logic [15:0] core_wdata = '0;
  logic [3:0]  wait_prog = '0;
  logic [15:0] core_rdata;
  logic        core_done;
  logic [15:0] mem_addr;
  logic        mem_space;
  logic        mem_bs_n, mem_rd_n, mem_wr_n, ctl_oe;
  logic        mem_ack_n = 1'b1;
  logic [15:0] dbus_in = '0;
  logic [15:0] dbus_out;
  logic        dbus_oe;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mbus_seq u0 (
    .clk(clk), .rst_n(rst_n), .bus_grant(bus_grant), .core_req(core_req),
    .core_wr(core_wr), .core_space(core_space), .core_addr(core_addr),
    .core_wdata(core_wdata), .wait_prog(wait_prog), .core_rdata(core_rdata),
    .core_done(core_done), .mem_addr(mem_addr), .mem_space(mem_space),
    .mem_bs_n(mem_bs_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .ctl_oe(ctl_oe), .mem_ack_n(mem_ack_n), .dbus_in(dbus_in),
    .dbus_out(dbus_out), .dbus_oe(dbus_oe)
  );

  // Vector: {wr, waits_prog[3:0], first_ack_edge[4:0], pulse, addr[15:0], data[15:0]}
  localparam int NV = 10;
  localparam logic [42:0] VEC [NV] = '{
    {1'b1, 4'd0,  5'd0,  1'b0, 16'h1234, 16'hABCD},  // R6 zero-wait write
    {1'b0, 4'd0,  5'd0,  1'b0, 16'h0041, 16'hBEEF},  // R6 zero-wait read
    {1'b1, 4'd2,  5'd0,  1'b0, 16'h2002, 16'h5A5A},  // R5 programmed waits
    {1'b0, 4'd0,  5'd5,  1'b0, 16'h3003, 16'hC3C3},  // R7 ack-driven waits
    {1'b0, 4'd4,  5'd3,  1'b0, 16'h4005, 16'h0F0F},  // R5 register wins
    {1'b1, 4'd1,  5'd6,  1'b0, 16'h5006, 16'h9999},  // R5 ack wins
    {1'b0, 4'd0,  5'd1,  1'b1, 16'h6007, 16'h7E7E},  // R7 pulse before T2 retained
    {1'b1, 4'd0,  5'd0,  1'b1, 16'h7008, 16'h1111},  // R6 ack high at T2
    {1'b0, 4'd15, 5'd0,  1'b0, 16'h8009, 16'h2222},  // R5 largest register count
    {1'b1, 4'd0,  5'd20, 1'b0, 16'h900A, 16'h3333}   // R7 long ack stretch
  };

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [5:0] pins();
    return {ctl_oe, mem_bs_n, mem_rd_n, mem_wr_n, dbus_oe, core_done};
  endfunction

  localparam logic [5:0] QUIET = 6'b1_1_1_1_0_0;

  // Runs one access starting at a negedge; returns at a negedge, idle.
  task automatic run_cycle(input logic [42:0] v, input bit extra_req);
    logic        wr, pulse;
    logic [15:0] a, d;
    int          w, f, k, waits, last;
    logic        strb;
    logic [5:0]  exp;
    wr = v[42]; w = int'(v[41:38]); f = int'(v[37:33]); pulse = v[32];
    a = v[31:16]; d = v[15:0];
    k = (f > 2) ? f - 2 : 0;
    waits = (w > k) ? w : k;
    last = 3 + waits;
    core_req = 1'b1; core_wr = wr; core_addr = a; core_space = ~a[0];
    core_wdata = d; wait_prog = w[3:0];
    mem_ack_n = (f == 0) ? 1'b0 : 1'b1;
    dbus_in = ~d;
    for (int p = 0; p <= last + 1; p++) begin
      @(posedge clk); @(negedge clk);
      core_req = 1'b0;
      if (extra_req && p == 1) begin
        core_req = 1'b1; core_addr = ~a; core_space = a[0]; core_wdata = ~d;
      end
      mem_ack_n = pulse ? (p + 1 != f) : (p + 1 < f);
      dbus_in = (p + 1 == last) ? d : ~d;
      strb = (p >= 1) && (p <= last - 1);
      exp = {1'b1, ~(p <= 1), ~(strb && !wr), ~(strb && wr),
             (wr && p >= 2 && p <= last), (p == last)};
      chk(wr ? "R2 R3 R5" : "R2 R4 R5", $sformatf("pins phase %0d", p),
          32'(pins()), 32'(exp));
      if (strb)
        chk("R9", $sformatf("addr phase %0d", p),
            {15'd0, mem_space, mem_addr}, {15'd0, ~a[0], a});
      if (wr && (p == 2 || p == last))
        chk("R3", "write data", 32'(dbus_out), 32'(d));
      if (!wr && p == last)
        chk("R4", "read capture", 32'(core_rdata), 32'(d));
    end
    core_req = 1'b0;
    mem_ack_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "pins in reset", 32'(pins()), 32'(6'b0_1_1_1_0_0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "pins after reset", 32'(pins()), 32'(QUIET));

    // Table walk
    for (int i = 0; i < NV; i++) run_cycle(VEC[i], 1'b0);

    // R8: acknowledge toggling while idle
    for (int i = 0; i < 6; i++) begin
      mem_ack_n = i[0];
      @(negedge clk);
      chk("R8", "idle pins with ack toggling", 32'(pins()), 32'(QUIET));
    end
    mem_ack_n = 1'b1;
    @(negedge clk);
    run_cycle({1'b0, 4'd0, 5'd4, 1'b0, 16'hA00B, 16'h4444}, 1'b0);  // R8 two waits expected

    // R11: request during an access ignored
    run_cycle({1'b1, 4'd1, 5'd0, 1'b0, 16'hB00C, 16'h5555}, 1'b1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R11", "no second access", 32'(pins()), 32'(QUIET));
    end

    // R10: no grant
    bus_grant = 1'b0;
    core_req = 1'b1; core_wr = 1'b1; core_addr = 16'hC00D;
    @(negedge clk);
    core_req = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk("R10", "no grant", 32'(pins()), 32'(6'b0_1_1_1_0_0));
      @(negedge clk);
    end
    bus_grant = 1'b1;
    @(negedge clk);
    chk("R10", "request not kept", 32'(pins()), 32'(QUIET));

    // R1: reset in the middle of an access
    core_req = 1'b1; core_wr = 1'b1; wait_prog = 4'd3; mem_ack_n = 1'b0;
    @(posedge clk); @(negedge clk);
    core_req = 1'b0;
    repeat (2) begin @(posedge clk); @(negedge clk); end
    rst_n = 1'b0;
    #1;
    chk("R1", "reset mid-access", 32'(pins()), 32'(6'b0_1_1_1_0_0));
    @(negedge clk);
    rst_n = 1'b1;
    mem_ack_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle after mid reset", 32'(pins()), 32'(QUIET));
    run_cycle({1'b0, 4'd2, 5'd0, 1'b0, 16'hD00E, 16'h6666}, 1'b0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule